// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block gathers up to 32 level-sensitive interrupt request lines from peripherals and drives one IRQ line to a processor. A per-source enable mask gates the requests. Sixteen vector slots each take a request-line number, an enable bit and a handler address. An enabled slot whose source is active is a vectored request. Among these, the lowest-numbered slot wins. Enabled requests that no enabled slot claims are non-vectored and rank below every vectored one.

The interrupt entry code reads one vector word. It gets the handler address of the winning slot, or a shared default address when no vectored request is pending. The default handler can then read a status word to find which enabled lines are active. A raw status word shows the request lines before masking. Software reaches the registers through a word-addressed bus. Writes and reads each use a single-cycle strobe. Every read returns its data one cycle after the strobe, and that data is held until the next read.

Top module: `vicp_top`

## Requirements
- R1: After reset, the enable mask is all zero, every slot is disabled with source 0 and handler 0, the default address is 0, `irq_o` is 0, and `rd_data_o` is 0.
- R2: Writing word 2 sets the mask bits where the write data has 1s. Writing word 3 clears the mask bits where the write data has 1s. Zero bits in either write leave the mask unchanged. A read of word 2 returns the mask.
- R3: `irq_o` is 1 in the same cycle that any request line is high while its mask bit is set, and 0 otherwise.
- R4: When at least one enabled slot names an active, enabled request line, a read of word 5 returns the handler address of the lowest-numbered such slot.
- R5: Slot k's control word is at word 32+k: bits [4:0] hold the source line and bit 5 is the slot enable. Its handler address is at word 48+k. Any source may be bound to any slot, and a disabled slot never wins.
- R6: If two enabled slots name the same active source, the lower-numbered slot wins.
- R7: When no enabled slot has an active source, a read of word 5 returns the default address, which is stored at word 4.
- R8: A read of word 0 returns the raw request lines. A read of word 1 returns the request lines ANDed with the mask.
- R9: `rd_data_o` takes its new value at the clock edge where `rd_en_i` is high. It keeps that value while `rd_en_i` stays low, even if requests change.
- R10: A read and a write in the same cycle are both done. The read returns the state from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_req_i | input | 32 | Level-sensitive request lines |
| wr_en_i | input | 1 | Write strobe, one cycle |
| wr_addr_i | input | 7 | Word address for the write |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe, one cycle |
| rd_addr_i | input | 7 | Word address for the read |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt to the processor |

## Verification
A mask-clear write and a vector read can fall in the same clock edge. The bench provokes this by clearing the source of the current winning slot in the cycle where it reads the vector word. The captured vector must still be the old winner's address. The next read must give the next slot in priority order, or the default address. Random runs mix slot reprogramming, mask changes and request patterns. Each vector read is compared with a priority scan done by a bench function.

// File: rtl/vicp_pkg.sv
package vicp_pkg;
   // word addresses of the register file
   localparam int unsigned W_RAW       = 0;
   localparam int unsigned W_ACT       = 1;
   localparam int unsigned W_ENSET     = 2;
   localparam int unsigned W_ENCLR     = 3;
   localparam int unsigned W_DFLT      = 4;
   localparam int unsigned W_VEC       = 5;
   localparam int unsigned W_CTRL_BASE = 32;
   localparam int unsigned W_HADR_BASE = 48;
   localparam int unsigned CTRL_EN_BIT = 5;
   localparam int unsigned MAX_SLOTS   = 16;
endpackage

// File: rtl/vicp_slot_bank.sv
module vicp_slot_bank
   import vicp_pkg::*;
#(
   parameter int unsigned N_SLOT = 16,
   parameter int unsigned SRC_W  = 5,
   parameter int unsigned DW     = 32,
   parameter int unsigned AW     = 7
) (
   input  logic                            clk_i,
   input  logic                            rst_ni,
   input  logic                            wr_en_i,
   input  logic [AW-1:0]                   wr_addr_i,
   input  logic [DW-1:0]                   wr_data_i,
   output logic [N_SLOT-1:0]               slot_en_o,
   output logic [N_SLOT-1:0][SRC_W-1:0]    slot_src_o,
   output logic [N_SLOT-1:0][DW-1:0]       slot_hadr_o
);
   for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
      logic ctrl_we, hadr_we;
      assign ctrl_we = wr_en_i && (wr_addr_i == AW'(W_CTRL_BASE + g));
      assign hadr_we = wr_en_i && (wr_addr_i == AW'(W_HADR_BASE + g));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            slot_en_o[g]  <= 1'b0;
            slot_src_o[g] <= '0;
         end else if (ctrl_we) begin
            slot_en_o[g]  <= wr_data_i[CTRL_EN_BIT];
            slot_src_o[g] <= wr_data_i[SRC_W-1:0];
         end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)      slot_hadr_o[g] <= '0;
         else if (hadr_we) slot_hadr_o[g] <= wr_data_i;
      end
   end
endmodule

// File: rtl/vicp_resolve.sv
module vicp_resolve #(
   parameter int unsigned N_SRC  = 32,
   parameter int unsigned N_SLOT = 16,
   parameter int unsigned SRC_W  = 5,
   localparam int unsigned SLOT_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
   input  logic [N_SRC-1:0]             act_i,
   input  logic [N_SLOT-1:0]            slot_en_i,
   input  logic [N_SLOT-1:0][SRC_W-1:0] slot_src_i,
   output logic [N_SLOT-1:0]            hit_o,
   output logic                         any_o,
   output logic [SLOT_W-1:0]            win_o
);
   for (genvar g = 0; g < N_SLOT; g++) begin : g_hit
      assign hit_o[g] = slot_en_i[g] && act_i[slot_src_i[g]];
   end

   assign any_o = |hit_o;

   // scan from the lowest priority upward so slot 0 is assigned last
   always_comb begin
      win_o = '0;
      for (int k = N_SLOT - 1; k >= 0; k--) begin
         if (hit_o[k]) win_o = SLOT_W'(k);
      end
   end
endmodule

// File: rtl/vicp_top.sv
module vicp_top
   import vicp_pkg::*;
#(
   parameter int unsigned N_SRC  = 32,
   parameter int unsigned N_SLOT = 16,
   parameter int unsigned DW     = 32,
   parameter int unsigned AW     = 7
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [31:0]     irq_req_i,
   input  logic            wr_en_i,
   input  logic [6:0]      wr_addr_i,
   input  logic [31:0]     wr_data_i,
   input  logic            rd_en_i,
   input  logic [6:0]      rd_addr_i,
   output logic [31:0]     rd_data_o,
   output logic            irq_o
);
   localparam int unsigned SRC_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1;
   localparam int unsigned SLOT_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1;

   if (N_SLOT > MAX_SLOTS || N_SLOT < 1) begin : g_bad_slots
      $error("vicp_top: N_SLOT must be 1..16");
   end
   if (N_SRC > DW || N_SRC < 2) begin : g_bad_src
      $error("vicp_top: N_SRC must be 2..DW");
   end
   if (DW != 32 || AW != 7 || N_SRC != 32) begin : g_bad_bus
      $error("vicp_top: port widths are fixed at 32/7 with 32 sources");
   end

   logic [N_SRC-1:0]             en_mask;
   logic [N_SRC-1:0]             act;
   logic [N_SLOT-1:0]            slot_en;
   logic [N_SLOT-1:0][SRC_W-1:0] slot_src;
   logic [N_SLOT-1:0][DW-1:0]    slot_hadr;
   logic [N_SLOT-1:0]            slot_hit;
   logic                         vec_any;
   logic [SLOT_W-1:0]            win_idx;
   logic [DW-1:0]                dflt_addr;
   logic [DW-1:0]                vec_val;
   logic [DW-1:0]                rd_mux;
   logic [3:0]                   rd_sel;

   assign act   = irq_req_i[N_SRC-1:0] & en_mask;
   assign irq_o = |act;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_mask   <= '0;
         dflt_addr <= '0;
      end else if (wr_en_i) begin
         if (wr_addr_i == AW'(W_ENSET)) en_mask <= en_mask | wr_data_i[N_SRC-1:0];
         if (wr_addr_i == AW'(W_ENCLR)) en_mask <= en_mask & ~wr_data_i[N_SRC-1:0];
         if (wr_addr_i == AW'(W_DFLT))  dflt_addr <= wr_data_i;
      end
   end

   vicp_slot_bank #(.N_SLOT(N_SLOT), .SRC_W(SRC_W), .DW(DW), .AW(AW)) u_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_en_i     (wr_en_i),
      .wr_addr_i   (wr_addr_i),
      .wr_data_i   (wr_data_i),
      .slot_en_o   (slot_en),
      .slot_src_o  (slot_src),
      .slot_hadr_o (slot_hadr)
   );

   vicp_resolve #(.N_SRC(N_SRC), .N_SLOT(N_SLOT), .SRC_W(SRC_W)) u_res (
      .act_i      (act),
      .slot_en_i  (slot_en),
      .slot_src_i (slot_src),
      .hit_o      (slot_hit),
      .any_o      (vec_any),
      .win_o      (win_idx)
   );

   assign vec_val = vec_any ? slot_hadr[win_idx] : dflt_addr;
   assign rd_sel  = rd_addr_i[3:0];

   always_comb begin
      rd_mux = '0;
      if (rd_addr_i == AW'(W_RAW))        rd_mux = irq_req_i;
      else if (rd_addr_i == AW'(W_ACT))   rd_mux = DW'(act);
      else if (rd_addr_i == AW'(W_ENSET)) rd_mux = DW'(en_mask);
      else if (rd_addr_i == AW'(W_DFLT))  rd_mux = dflt_addr;
      else if (rd_addr_i == AW'(W_VEC))   rd_mux = vec_val;
      else if (rd_addr_i >= AW'(W_CTRL_BASE) && rd_addr_i < AW'(W_CTRL_BASE + N_SLOT))
         rd_mux = DW'({slot_en[rd_sel], slot_src[rd_sel]});
      else if (rd_addr_i >= AW'(W_HADR_BASE) && rd_addr_i < AW'(W_HADR_BASE + N_SLOT))
         rd_mux = slot_hadr[rd_sel];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      rd_data_o <= '0;
      else if (rd_en_i) rd_data_o <= rd_mux;
   end
endmodule

// File: rtl/vicp_chk.sv
module vicp_chk
   import vicp_pkg::*;
#(
   parameter int unsigned N_SRC  = 32,
   parameter int unsigned N_SLOT = 16,
   localparam int unsigned SLOT_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [31:0]       req,
   input logic [N_SRC-1:0]  mask,
   input logic              irq,
   input logic              wr_en,
   input logic [6:0]        wr_addr,
   input logic [31:0]       wr_data,
   input logic              rd_en,
   input logic [31:0]       rd_data,
   input logic [N_SLOT-1:0] hit,
   input logic              any,
   input logic [SLOT_W-1:0] win
);
   AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      irq == |(req[N_SRC-1:0] & mask)); // R3

   AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 7'(W_ENSET)) |=>
      ((mask & $past(wr_data[N_SRC-1:0])) == $past(wr_data[N_SRC-1:0]))); // R2

   AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 7'(W_ENCLR)) |=>
      ((mask & $past(wr_data[N_SRC-1:0])) == '0)); // R2

   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data)); // R9

   AST_WIN_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> hit[win]); // R4

   AST_WIN_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> ((hit & ((N_SLOT'(1) << win) - N_SLOT'(1))) == '0)); // R6

   AST_VEC_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> irq); // R3
endmodule

bind vicp_top vicp_chk #(.N_SRC(N_SRC), .N_SLOT(N_SLOT)) u_chk (
   .clk     (clk_i),
   .rst_n   (rst_ni),
   .req     (irq_req_i),
   .mask    (en_mask),
   .irq     (irq_o),
   .wr_en   (wr_en_i),
   .wr_addr (wr_addr_i),
   .wr_data (wr_data_i),
   .rd_en   (rd_en_i),
   .rd_data (rd_data_o),
   .hit     (slot_hit),
   .any     (vec_any),
   .win     (win_idx)
);

// File: tb/sim_vicp_top.sv
`timescale 1ns/1ps
module sim_vicp_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] req = '0;
   logic        wr_en = 1'b0;
   logic [6:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [6:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        irq;

   int total = 0;
   int bad   = 0;

   // bench model of the programmed state
   logic [31:0] m_mask;
   logic [31:0] m_dflt;
   logic [4:0]  m_src  [16];
   logic        m_en   [16];
   logic [31:0] m_hadr [16];

   always #2 clk = ~clk;

   vicp_top u0 (
      .clk_i(clk), .rst_ni(rst_n), .irq_req_i(req),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
   );

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: run did not finish act=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   function automatic logic [31:0] exp_vec(input logic [31:0] r);
      logic [31:0] a = r & m_mask;
      for (int k = 0; k < 16; k++)
         if (m_en[k] && a[m_src[k]]) return m_hadr[k];
      return m_dflt;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [6:0] a, output logic [31:0] v);
      @(negedge clk); rd_en = 1'b1; rd_addr = a;
      @(posedge clk); #1 v = rd_data;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic set_slot(input int k, input logic [4:0] s, input logic e, input logic [31:0] h);
      wr(7'(32 + k), {26'b0, e, s});
      wr(7'(48 + k), h);
      m_src[k] = s; m_en[k] = e; m_hadr[k] = h;
   endtask

   task automatic mask_set(input logic [31:0] d);
      wr(7'd2, d); m_mask = m_mask | d;
   endtask

   task automatic mask_clr(input logic [31:0] d);
      wr(7'd3, d); m_mask = m_mask & ~d;
   endtask

   initial begin
      logic [31:0] v;
      logic [31:0] r;
      void'($urandom(32'd20240611));
      m_mask = '0; m_dflt = '0;
      for (int k = 0; k < 16; k++) begin m_src[k] = '0; m_en[k] = 1'b0; m_hadr[k] = '0; end

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 rd_data reset", rd_data, 32'h0);
      check("R1 irq reset", {31'b0, irq}, 32'h0);
      rd(7'd2, v);  check("R1 mask reset", v, 32'h0);
      rd(7'd4, v);  check("R1 default reset", v, 32'h0);
      rd(7'd37, v); check("R1 slot5 ctrl reset", v, 32'h0);
      rd(7'd53, v); check("R1 slot5 handler reset", v, 32'h0);
      req = 32'hFFFF_FFFF;
      #1 check("R1 irq masked at reset", {31'b0, irq}, 32'h0);

      // mask and status
      wr(7'd4, 32'hD00D_0000); m_dflt = 32'hD00D_0000;
      mask_set(32'h0000_0288);
      req = 32'h0000_0028;
      #1 check("R3 irq on enabled line", {31'b0, irq}, 32'h1);
      rd(7'd0, v); check("R8 raw status", v, 32'h0000_0028);
      rd(7'd1, v); check("R8 active status", v, 32'h0000_0008);
      rd(7'd2, v); check("R2 mask after set", v, 32'h0000_0288);
      rd(7'd5, v); check("R7 default with no slots", v, 32'hD00D_0000);

      // binding, disabled slot ignored
      set_slot(0, 5'd3, 1'b0, 32'h0000_00A0);
      set_slot(2, 5'd3, 1'b1, 32'h0000_00A2);
      rd(7'd34, v); check("R5 slot2 ctrl readback", v, 32'h0000_0023);
      rd(7'd5, v); check("R5 disabled slot0 skipped", v, 32'h0000_00A2);
      set_slot(5, 5'd7, 1'b1, 32'h0000_00A5);
      req = 32'h0000_0080;
      rd(7'd5, v); check("R4 single slot5", v, 32'h0000_00A5);
      req = 32'h0000_0088;
      rd(7'd5, v); check("R4 slot2 over slot5", v, 32'h0000_00A2);
      set_slot(1, 5'd3, 1'b1, 32'h0000_00A1);
      rd(7'd5, v); check("R6 duplicate source lower slot", v, 32'h0000_00A1);

      // read and mask-clear in the same edge
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 7'd3; wr_data = 32'h0000_0008;
      rd_en = 1'b1; rd_addr = 7'd5;
      @(posedge clk); #1 v = rd_data;
      @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
      m_mask = m_mask & ~32'h0000_0008;
      check("R10 read sees pre-write winner", v, 32'h0000_00A1);
      rd(7'd5, v); check("R10 next winner after clear", v, 32'h0000_00A5);
      rd(7'd2, v); check("R2 clear leaves zero bits", v, 32'h0000_0280);

      // hold
      req = 32'h0;
      repeat (3) @(negedge clk);
      check("R9 rd_data held without strobe", rd_data, 32'h0000_0280);
      rd(7'd5, v); check("R7 default when idle", v, 32'hD00D_0000);
      req = 32'h0000_0020;
      #1 check("R3 masked-off line gives no irq", {31'b0, irq}, 32'h0);

      // random phase
      for (int it = 0; it < 400; it++) begin
         if ($urandom_range(2) == 0)
            set_slot($urandom_range(15), 5'($urandom), 1'($urandom), $urandom);
         if ($urandom_range(3) == 0) mask_set($urandom & $urandom);
         if ($urandom_range(3) == 0) mask_clr($urandom & $urandom);
         r = $urandom & $urandom & $urandom;
         @(negedge clk); req = r;
         #1 check("R3 random irq", {31'b0, irq}, {31'b0, |(r & m_mask)});
         rd(7'd5, v); check("R4 random vector", v, exp_vec(r));
         rd(7'd1, v); check("R8 random active", v, r & m_mask);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule